// File: doc/BRIEF.md
# Hypercube Node Router

This block is the switch inside one node of a binary hypercube network of dimension `DIM`. The network has 2^DIM nodes, each named by a DIM-bit address, and every node is wired to DIM neighbours. The neighbour on link `k` has the same address as this node except for bit `k`. The router has DIM link ports and one local port, which together make `DIM+1` ports. Each port has an input side and an output side. Packets are a single flit: a destination address, a hop count and a payload. Each side uses a valid/ready handshake.

For each waiting input packet, the router XORs the destination with the node address. If the result is zero, the packet is ejected on the local port (index `DIM`). Otherwise the packet leaves on the link given by the lowest differing bit. Each forward brings the packet one Hamming step closer to its destination, so any packet arrives within DIM hops. Each output port has its own round-robin arbiter that settles contention between inputs. When a grant is stalled by back-pressure, the arbiter holds it until the grant completes. On every link forward the hop count is incremented. A forward whose new count exceeds DIM raises a one-cycle error pulse.

Each arbiter is a two-state machine. In `ARB_OPEN` it grants the first requester found at or after its rotating pointer. The transition OPEN→OPEN (granted and accepted) moves the pointer past the winner. The transition OPEN→HOLD (granted but not accepted) records the winner. In `ARB_HOLD` the recorded input keeps the grant. The transition HOLD→OPEN happens on acceptance, which moves the pointer past that input, or when the held request is withdrawn.

Top module: `hcube_router`

## Requirements
- R1: While reset is asserted and no input is valid, every `out_valid_o` and `in_ready_o` bit is 0 and `hop_err_o` is 0.
- R2: A packet whose destination equals `node_addr_i` leaves on output port index DIM (local) with destination, hop count and payload unchanged.
- R3: A packet whose destination differs from `node_addr_i` leaves on output port k, where k is the lowest bit position in which the two addresses differ; bits below k are equal, so the next node is one Hamming step closer.
- R4: A packet forwarded on a link port carries hop count equal to its input hop count plus one (modulo 2^HOPW).
- R5: When several inputs want the same output, the grant goes to the first requester at or after the port index following the last input served on that output (index order wraps from DIM to 0); after reset that search starts at input 0.
- R6: While an output shows valid with ready low, it keeps showing the same packet in the next cycle, even if other inputs start requesting that output.
- R7: `in_ready_o[i]` is 1 in exactly the cycles where input i is valid, holds the grant of the output it routes to, and that output's ready is 1. Outputs and ready bits are combinational in the same cycle.
- R8: `hop_err_o` is 1 in the cycle after a cycle in which some link port completes a transfer whose outgoing hop count exceeds DIM, and 0 otherwise.
- R9: Different output ports serve different inputs in the same cycle, independently of each other.
- R10: The payload and destination reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr_i | input | DIM | Address of this node |
| in_valid_i | input | DIM+1 | Input valid per port (index DIM is local injection) |
| in_ready_o | output | DIM+1 | Input accepted per port |
| in_dst_i | input | (DIM+1)*DIM | Destination per input, port i at bits [i*DIM +: DIM] |
| in_hops_i | input | (DIM+1)*HOPW | Hop count per input |
| in_data_i | input | (DIM+1)*DW | Payload per input |
| out_valid_o | output | DIM+1 | Output valid per port (index k = link k, DIM = local) |
| out_ready_i | input | DIM+1 | Downstream ready per output |
| out_dst_o | output | (DIM+1)*DIM | Destination per output |
| out_hops_o | output | (DIM+1)*HOPW | Hop count per output |
| out_data_o | output | (DIM+1)*DW | Payload per output |
| hop_err_o | output | 1 | Hop-limit error pulse |

## Verification
Routing, grant and ready results are combinational. They are due in the same cycle the inputs are presented, so the bench drives on the falling edge and samples two nanoseconds later, before the next rising edge. Arbiter pointer and hold state change at the rising edge, so each effect is first checked in the following cycle. The hop error is registered and is due exactly one cycle after the offending transfer. The bench carries the expected flag into the next sample.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_t;
endpackage

// File: rtl/hcr_route.sv
module hcr_route #(
    parameter int DIM = 3,
    localparam int PIW = $clog2(DIM + 1)
) (
    input  logic [DIM-1:0] node_i,
    input  logic [DIM-1:0] dst_i,
    output logic [PIW-1:0] port_o
);
    logic [DIM-1:0] diff;

    always_comb begin
        diff   = node_i ^ dst_i;
        port_o = PIW'(DIM);
        for (int k = DIM - 1; k >= 0; k--) begin
            if (diff[k]) port_o = PIW'(k);
        end
    end
endmodule

// File: rtl/hcr_arb.sv
module hcr_arb
    import hcr_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          ready_i,
    output logic          gnt_vld_o,
    output logic [IW-1:0] gnt_idx_o
);
    arb_state_t    state_q, state_d;
    logic [IW-1:0] ptr_q, ptr_d;
    logic [IW-1:0] hold_q, hold_d;
    logic          pick_vld;
    logic [IW-1:0] pick;

    function automatic logic [IW-1:0] after(input logic [IW-1:0] idx);
        return (int'(idx) == N - 1) ? '0 : idx + 1'b1;
    endfunction

    // rotating search from the pointer
    always_comb begin
        pick_vld = 1'b0;
        pick     = ptr_q;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!pick_vld && req_i[idx]) begin
                pick_vld = 1'b1;
                pick     = IW'(idx);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        hold_d  = hold_q;
        unique case (state_q)
            ARB_OPEN: begin
                if (pick_vld && ready_i) begin
                    ptr_d = after(pick);
                end else if (pick_vld) begin
                    state_d = ARB_HOLD;
                    hold_d  = pick;
                end
            end
            ARB_HOLD: begin
                if (!req_i[hold_q]) begin
                    state_d = ARB_OPEN;
                end else if (ready_i) begin
                    state_d = ARB_OPEN;
                    ptr_d   = after(hold_q);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_OPEN;
            ptr_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            hold_q  <= hold_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ARB_OPEN: begin
                gnt_vld_o = pick_vld;
                gnt_idx_o = pick;
            end
            ARB_HOLD: begin
                gnt_vld_o = req_i[hold_q];
                gnt_idx_o = hold_q;
            end
        endcase
    end
endmodule

// File: rtl/hcube_router.sv
module hcube_router #(
    parameter int DIM  = 3,
    parameter int HOPW = 4,
    parameter int DW   = 8,
    localparam int NP  = DIM + 1,
    localparam int PIW = $clog2(NP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIM-1:0]   node_addr_i,
    input  logic [NP-1:0]    in_valid_i,
    output logic [NP-1:0]    in_ready_o,
    input  logic [NP*DIM-1:0]  in_dst_i,
    input  logic [NP*HOPW-1:0] in_hops_i,
    input  logic [NP*DW-1:0]   in_data_i,
    output logic [NP-1:0]    out_valid_o,
    input  logic [NP-1:0]    out_ready_i,
    output logic [NP*DIM-1:0]  out_dst_o,
    output logic [NP*HOPW-1:0] out_hops_o,
    output logic [NP*DW-1:0]   out_data_o,
    output logic             hop_err_o
);
    logic [PIW-1:0] route  [NP];
    logic [NP-1:0]  req_m  [NP];
    logic [NP-1:0]  gnt_vld;
    logic [PIW-1:0] gnt_idx [NP];
    logic [NP-1:0]  over;
    logic           hop_err_q;

    for (genvar i = 0; i < NP; i++) begin : g_in
        hcr_route #(.DIM(DIM)) route_i (
            .node_i (node_addr_i),
            .dst_i  (in_dst_i[i*DIM +: DIM]),
            .port_o (route[i])
        );
    end

    for (genvar j = 0; j < NP; j++) begin : g_out
        always_comb begin
            for (int i = 0; i < NP; i++) begin
                req_m[j][i] = in_valid_i[i] && (int'(route[i]) == j);
            end
        end

        hcr_arb #(.N(NP)) arb_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req_m[j]),
            .ready_i   (out_ready_i[j]),
            .gnt_vld_o (gnt_vld[j]),
            .gnt_idx_o (gnt_idx[j])
        );

        always_comb begin
            int          s;
            logic [HOPW:0] nh;
            s  = int'(gnt_idx[j]);
            nh = {1'b0, in_hops_i[s*HOPW +: HOPW]} + ((j < DIM) ? 1'b1 : 1'b0);
            out_valid_o[j]             = gnt_vld[j];
            out_dst_o[j*DIM +: DIM]    = in_dst_i[s*DIM +: DIM];
            out_data_o[j*DW +: DW]     = in_data_i[s*DW +: DW];
            out_hops_o[j*HOPW +: HOPW] = nh[HOPW-1:0];
            over[j] = (j < DIM) && gnt_vld[j] && out_ready_i[j] && (int'(nh) > DIM);
        end
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_ready_o[i] = 1'b0;
            for (int j = 0; j < NP; j++) begin
                if (gnt_vld[j] && out_ready_i[j] && int'(gnt_idx[j]) == i)
                    in_ready_o[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hop_err_q <= 1'b0;
        else        hop_err_q <= |over;
    end

    assign hop_err_o = hop_err_q;
endmodule

// File: rtl/hcube_router_chk.sv
module hcube_router_chk #(
    parameter int DIM  = 3,
    parameter int HOPW = 4,
    parameter int DW   = 8,
    localparam int NP  = DIM + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DIM-1:0]     node_addr_i,
    input logic [NP-1:0]      in_valid_i,
    input logic [NP-1:0]      in_ready_o,
    input logic [NP-1:0]      out_valid_o,
    input logic [NP-1:0]      out_ready_i,
    input logic [NP*DIM-1:0]  out_dst_o,
    input logic [NP*HOPW-1:0] out_hops_o,
    input logic [NP*DW-1:0]   out_data_o
);
    for (genvar j = 0; j < DIM; j++) begin : g_link
        localparam logic [DIM-1:0] LOW = DIM'((1 << j) - 1);
        // R3
        link_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o[j] |-> ((out_dst_o[j*DIM +: DIM] ^ node_addr_i) & LOW) == '0
                               && (out_dst_o[j*DIM + j] != node_addr_i[j]));
    end

    // R2
    local_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o[DIM] |-> out_dst_o[DIM*DIM +: DIM] == node_addr_i);

    for (genvar j = 0; j < NP; j++) begin : g_port
        // R6
        stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o[j] && !out_ready_i[j]) |=> out_valid_o[j]
                && $stable(out_dst_o[j*DIM +: DIM])
                && $stable(out_hops_o[j*HOPW +: HOPW])
                && $stable(out_data_o[j*DW +: DW]));
        // R7
        ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_ready_o[j] |-> in_valid_i[j]);
    end
endmodule

bind hcube_router hcube_router_chk #(.DIM(DIM), .HOPW(HOPW), .DW(DW)) chk_i (.*);

// File: tb/hcube_router_tb_top.sv
`timescale 1ns/1ps
module hcube_router_tb_top;
    localparam int DIM  = 3;
    localparam int HOPW = 4;
    localparam int DW   = 8;
    localparam int NP   = DIM + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIM-1:0]     node_addr;
    logic [NP-1:0]      in_valid, in_ready, out_valid, out_ready;
    logic [NP*DIM-1:0]  in_dst, out_dst;
    logic [NP*HOPW-1:0] in_hops, out_hops;
    logic [NP*DW-1:0]   in_data, out_data;
    logic               hop_err;

    always #10 clk = ~clk;

    hcube_router #(.DIM(DIM), .HOPW(HOPW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .node_addr_i(node_addr),
        .in_valid_i(in_valid), .in_ready_o(in_ready),
        .in_dst_i(in_dst), .in_hops_i(in_hops), .in_data_i(in_data),
        .out_valid_o(out_valid), .out_ready_i(out_ready),
        .out_dst_o(out_dst), .out_hops_o(out_hops), .out_data_o(out_data),
        .hop_err_o(hop_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench-side packet and arbiter model
    bit             pv   [NP];
    logic [DIM-1:0] pdst [NP];
    logic [HOPW-1:0] phop [NP];
    logic [DW-1:0]  pdat [NP];
    bit             rdy  [NP];
    int             ptr  [NP];
    bit             held [NP];
    int             hidx [NP];
    bit             exp_err;
    bit             refill;

    function automatic int exp_route(logic [DIM-1:0] dst, logic [DIM-1:0] node);
        logic [DIM-1:0] d;
        d = dst ^ node;
        for (int k = 0; k < DIM; k++) if (d[k]) return k;
        return DIM;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic drive();
        for (int i = 0; i < NP; i++) begin
            in_valid[i]              = pv[i];
            in_dst[i*DIM +: DIM]     = pdst[i];
            in_hops[i*HOPW +: HOPW]  = phop[i];
            in_data[i*DW +: DW]      = pdat[i];
            out_ready[i]             = rdy[i];
        end
    endtask

    task automatic step(string tag);
        bit gv [NP];
        int g  [NP];
        bit xfer [NP];
        bit nerr;
        drive();
        #2;
        nerr = 0;
        for (int i = 0; i < NP; i++) xfer[i] = 0;
        for (int j = 0; j < NP; j++) begin
            gv[j] = 0; g[j] = 0;
            if (held[j]) begin
                gv[j] = pv[hidx[j]]; g[j] = hidx[j];
            end else begin
                for (int k = 0; k < NP; k++) begin
                    int idx;
                    idx = (ptr[j] + k) % NP;
                    if (!gv[j] && pv[idx] && exp_route(pdst[idx], node_addr) == j) begin
                        gv[j] = 1; g[j] = idx;
                    end
                end
            end
            check(out_valid[j] == gv[j], tag, $sformatf("out%0d valid", j), out_valid[j], gv[j]);
            if (gv[j]) begin
                logic [HOPW-1:0] eh;
                eh = (j < DIM) ? phop[g[j]] + 1'b1 : phop[g[j]];
                check(out_dst[j*DIM +: DIM] == pdst[g[j]], "R10",
                      $sformatf("out%0d dst", j), out_dst[j*DIM +: DIM], pdst[g[j]]);
                check(out_data[j*DW +: DW] == pdat[g[j]], "R10",
                      $sformatf("out%0d data", j), out_data[j*DW +: DW], pdat[g[j]]);
                check(out_hops[j*HOPW +: HOPW] == eh, "R4",
                      $sformatf("out%0d hops", j), out_hops[j*HOPW +: HOPW], eh);
                if (rdy[j]) begin
                    xfer[g[j]] = 1;
                    if (j < DIM && int'(phop[g[j]]) + 1 > DIM) nerr = 1;
                end
            end
        end
        for (int i = 0; i < NP; i++)
            check(in_ready[i] == xfer[i], "R7", $sformatf("in%0d ready", i), in_ready[i], xfer[i]);
        check(hop_err == exp_err, "R8", "hop_err", hop_err, exp_err);
        @(posedge clk);
        for (int j = 0; j < NP; j++) begin
            if (gv[j] && rdy[j]) begin
                ptr[j] = (g[j] + 1) % NP; held[j] = 0;
            end else if (gv[j]) begin
                held[j] = 1; hidx[j] = g[j];
            end else begin
                held[j] = 0;
            end
        end
        for (int i = 0; i < NP; i++) if (xfer[i]) pv[i] = 0;
        exp_err = nerr;
        @(negedge clk);
        if (refill) begin
            for (int i = 0; i < NP; i++) begin
                if (!pv[i] && $urandom_range(1, 0) == 1) begin
                    pv[i] = 1; pdst[i] = DIM'($urandom());
                    phop[i] = HOPW'($urandom_range(DIM, 0)); pdat[i] = DW'($urandom());
                end
            end
            for (int j = 0; j < NP; j++) rdy[j] = ($urandom_range(9, 0) < 7);
        end
    endtask

    task automatic put(int i, logic [DIM-1:0] dst, logic [HOPW-1:0] h, logic [DW-1:0] d);
        pv[i] = 1; pdst[i] = dst; phop[i] = h; pdat[i] = d;
    endtask

    task automatic all_ready(bit v);
        for (int j = 0; j < NP; j++) rdy[j] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        refill = 0; exp_err = 0;
        for (int i = 0; i < NP; i++) begin
            pv[i] = 0; pdst[i] = '0; phop[i] = '0; pdat[i] = '0; rdy[i] = 1;
            ptr[i] = 0; held[i] = 0; hidx[i] = 0;
        end
        node_addr = 3'b101;
        drive();
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == '0, "R1", "in_ready in reset", in_ready, 0);
        check(hop_err == 1'b0, "R1", "hop_err in reset", hop_err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1");

        // R2 local ejection
        put(1, 3'b101, 4'd2, 8'hA1); step("R2");
        // R3 lowest differing bit selects link 1 (diff 110)
        put(2, 3'b011, 4'd0, 8'hB2); step("R3");
        // R3 link 2 (diff 100)
        put(3, 3'b001, 4'd1, 8'hC3); step("R3");

        // R5 three inputs contend for link 0
        put(0, 3'b100, 4'd0, 8'h10);
        put(1, 3'b110, 4'd0, 8'h11);
        put(3, 3'b000, 4'd0, 8'h13);
        repeat (3) step("R5");

        // R6 stall on link 0, late higher-priority contender appears
        put(2, 3'b100, 4'd1, 8'h22);
        rdy[0] = 0;
        step("R6");
        put(0, 3'b110, 4'd1, 8'h20);
        repeat (2) step("R6");
        rdy[0] = 1;
        repeat (3) step("R6");

        // R9 four inputs to four distinct outputs
        put(0, 3'b100, 4'd0, 8'h40);
        put(1, 3'b111, 4'd0, 8'h41);
        put(2, 3'b001, 4'd0, 8'h42);
        put(3, 3'b101, 4'd0, 8'h43);
        step("R9");

        // R8 hop limit exceeded on a link, then a clean forward
        put(0, 3'b100, 4'd3, 8'h50); step("R8");
        put(1, 3'b100, 4'd1, 8'h51); step("R8");
        step("R8");

        // random traffic at two node addresses
        refill = 1;
        repeat (1500) step("R3");
        refill = 0; all_ready(1);
        repeat (10) step("R3");
        node_addr = 3'b010;
        refill = 1;
        repeat (1500) step("R5");
        refill = 0; all_ready(1);
        repeat (10) step("R5");

        done = 1;
        summary();
        $finish;
    end
endmodule